// File: doc/BRIEF.md
# Two-Channel Step-Adjusted PWM Generator

This block produces two pulse-width-modulated outputs. Each output's duty cycle is set by its own 6-bit level value. That value is never loaded directly. It is nudged one step at a time by a raise input and a lower input for that channel. A single free-running period counter is shared by both channels. Each channel compares the counter with its level and drives its output high while the counter is below the level, so the duty cycle is the level divided by 64.

The step inputs can come from two kinds of source, chosen by a select input. With select low, the inputs are treated as mechanical buttons: they are synchronised and debounced, and each accepted press gives one step. With select high, they are treated as clean logic pulses: each rising edge gives one step.

Reset and the shutdown input both return the two levels to half scale. Shutdown also holds both outputs low while it is asserted. A changed level reaches the comparator only at the start of a PWM period, so no period carries a truncated pulse.

Top module: `dual_pwm_dac`

## Requirements
- R1: After reset both levels are 32, so each output is high for 32 of every 64 clock cycles.
- R2: The PWM period is 64 clocks. An output is high while the shared counter is below its channel's level, which gives a duty cycle of level/64.
- R3: With `pulse_mode` = 1, each rising edge on a raise (lower) input moves that channel's level up (down) by exactly one.
- R4: With `pulse_mode` = 0, an input level becomes accepted only after it has held for 16 consecutive debounce ticks, with one tick every `TICK_DIV` clocks. Each accepted press (a 0-to-1 change of the accepted level) gives one step. A shorter glitch gives none.
- R5: The level saturates. A raise at 63 or a lower at 0 leaves it unchanged, with no wraparound.
- R6: Level 0 gives an output that is always low. Level 63 gives 63 high clocks per 64-clock period.
- R7: While `shutdown` is 1, both outputs are low. Both levels return to 32 and are 32 after `shutdown` is released.
- R8: A level change takes effect only at a period boundary. Every high pulse lasts exactly the old level or the new level, never a fraction of either.
- R9: If a raise step and a lower step for the same channel arrive in the same cycle, the level is unchanged.
- R10: The two channels are independent. Stepping one leaves the other's duty cycle unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shutdown | input | 1 | Forces outputs low and levels to half scale |
| pulse_mode | input | 1 | 1: clean pulse inputs, 0: debounced buttons |
| raise_in | input | 2 | Raise step input, one bit per channel |
| lower_in | input | 2 | Lower step input, one bit per channel |
| pwm_out | output | 2 | PWM output, one bit per channel |

## Verification
A wrong level register shows up directly as a wrong number of high clocks in a 64-clock window. It becomes visible within one to two periods after the faulty step, because the comparator picks up the level only at the next wrap. A wrong shadow load shows up as a runt pulse, meaning a high run that is neither the old level nor the new one, within the period in which the step lands. Debounce faults show up as missing or extra steps, roughly 70 clocks after a press or after a glitch.

// File: rtl/dpd_pkg.sv
package dpd_pkg;

    typedef enum logic {
        SRC_BUTTON = 1'b0,
        SRC_PULSE  = 1'b1
    } step_src_e;

    localparam int LANE_UP = 0;
    localparam int LANE_DN = 1;

endpackage

// File: rtl/dpd_timebase.sv
module dpd_timebase #(
    parameter int CODE_W   = 6,
    parameter int TICK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    output logic [CODE_W-1:0] cnt_o,
    output logic              wrap_o,
    output logic              tick_o
);
    localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;

    typedef struct packed {
        logic [CODE_W-1:0] cnt;
        logic [TW-1:0]     tdiv;
    } tb_state_t;

    tb_state_t q, d;

    always_comb begin
        d = q;
        d.cnt = q.cnt + 1'b1;
        if (q.tdiv == TW'(TICK_DIV - 1)) begin
            d.tdiv = '0;
        end else begin
            d.tdiv = q.tdiv + 1'b1;
        end
        if (clr_i) begin
            d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign cnt_o  = q.cnt;
    assign wrap_o = (q.cnt == {CODE_W{1'b1}});
    assign tick_o = (q.tdiv == TW'(TICK_DIV - 1));

    a_r2_period_advance: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (q.cnt == $past(q.cnt) + 1'b1));

endmodule

// File: rtl/dpd_step_cond.sv
module dpd_step_cond
    import dpd_pkg::*;
#(
    parameter int DEB_SAMPLES = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_i,
    input  logic       mode_i,
    input  logic       tick_i,
    input  logic [1:0] raw_i,
    output logic [1:0] step_o
);
    localparam int DW = (DEB_SAMPLES > 1) ? $clog2(DEB_SAMPLES) : 1;

    typedef struct packed {
        logic [1:0]         s1;
        logic [1:0]         s2;
        logic [1:0]         prev;
        logic [1:0]         stab;
        logic [1:0][DW-1:0] dcnt;
        logic [1:0]         step;
    } sc_state_t;

    sc_state_t q, d;
    logic [1:0] pulse_edge;
    logic [1:0] btn_edge;

    always_comb begin
        d = q;
        d.s1   = raw_i;
        d.s2   = q.s1;
        d.prev = q.s2;
        pulse_edge = q.s2 & ~q.prev;
        for (int k = 0; k < 2; k++) begin
            if (q.s2[k] == q.stab[k]) begin
                d.dcnt[k] = '0;
            end else if (tick_i) begin
                if (q.dcnt[k] == DW'(DEB_SAMPLES - 1)) begin
                    d.stab[k] = q.s2[k];
                    d.dcnt[k] = '0;
                end else begin
                    d.dcnt[k] = q.dcnt[k] + 1'b1;
                end
            end
        end
        btn_edge = d.stab & ~q.stab;
        d.step = (step_src_e'(mode_i) == SRC_PULSE) ? pulse_edge : btn_edge;
        if (clr_i) begin
            d.step = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign step_o = q.step;

    // R3: a pulse-mode step needs a synchronised rising edge
    a_r3_pulse_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && !clr_i && !$past(clr_i) && $past(mode_i) && step_o[LANE_UP])
            |-> $past(q.s2[LANE_UP] && !q.prev[LANE_UP]));

    // R4: an accepted button level only changes on a debounce tick
    a_r4_stab_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(q.stab));

endmodule

// File: rtl/dpd_channel.sv
module dpd_channel #(
    parameter int CODE_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              up_i,
    input  logic              dn_i,
    input  logic [CODE_W-1:0] cnt_i,
    input  logic              wrap_i,
    output logic              pwm_o
);
    localparam logic [CODE_W-1:0] LVL_MAX = {CODE_W{1'b1}};
    localparam logic [CODE_W-1:0] LVL_MID = {1'b1, {(CODE_W-1){1'b0}}};

    typedef struct packed {
        logic [CODE_W-1:0] lvl;
        logic [CODE_W-1:0] act;
        logic              pwm;
    } ch_state_t;

    ch_state_t q, d;

    always_comb begin
        d = q;
        if (up_i && !dn_i && q.lvl != LVL_MAX) begin
            d.lvl = q.lvl + 1'b1;
        end else if (dn_i && !up_i && q.lvl != '0) begin
            d.lvl = q.lvl - 1'b1;
        end
        if (wrap_i) begin
            d.act = q.lvl;
        end
        d.pwm = (cnt_i < q.act);
        if (clr_i) begin
            d.lvl = LVL_MID;
            d.act = LVL_MID;
            d.pwm = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.lvl <= LVL_MID;
            q.act <= LVL_MID;
            q.pwm <= 1'b0;
        end else begin
            q <= d;
        end
    end

    assign pwm_o = q.pwm;

    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (q.lvl == $past(q.lvl) || q.lvl == $past(q.lvl) + 1'b1
                    || q.lvl == $past(q.lvl) - 1'b1));

    a_r5_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
        (q.lvl == LVL_MAX && up_i && !clr_i) |=> q.lvl == LVL_MAX);

    a_r5_sat_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        (q.lvl == '0 && dn_i && !clr_i) |=> q.lvl == '0);

    a_r6_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        (q.act == '0) |=> !pwm_o);

    a_r7_shutdown: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (!pwm_o && q.lvl == LVL_MID));

    a_r8_load_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_i != '0) |-> $stable(q.act));

    a_r9_both_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (up_i && dn_i && !clr_i) |=> $stable(q.lvl));

endmodule

// File: rtl/dual_pwm_dac.sv
module dual_pwm_dac #(
    parameter int CODE_W      = 6,
    parameter int TICK_DIV    = 4,
    parameter int DEB_SAMPLES = 16,
    parameter int N_CH        = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            shutdown,
    input  logic            pulse_mode,
    input  logic [N_CH-1:0] raise_in,
    input  logic [N_CH-1:0] lower_in,
    output logic [N_CH-1:0] pwm_out
);
    logic [CODE_W-1:0] period_cnt;
    logic              period_wrap;
    logic              deb_tick;

    dpd_timebase #(
        .CODE_W  (CODE_W),
        .TICK_DIV(TICK_DIV)
    ) u_timebase (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (shutdown),
        .cnt_o (period_cnt),
        .wrap_o(period_wrap),
        .tick_o(deb_tick)
    );

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        logic [1:0] step;

        dpd_step_cond #(
            .DEB_SAMPLES(DEB_SAMPLES)
        ) u_cond (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (shutdown),
            .mode_i(pulse_mode),
            .tick_i(deb_tick),
            .raw_i ({lower_in[c], raise_in[c]}),
            .step_o(step)
        );

        dpd_channel #(
            .CODE_W(CODE_W)
        ) u_chan (
            .clk   (clk),
            .rst_n (rst_n),
            .clr_i (shutdown),
            .up_i  (step[0]),
            .dn_i  (step[1]),
            .cnt_i (period_cnt),
            .wrap_i(period_wrap),
            .pwm_o (pwm_out[c])
        );
    end

    a_r7_outputs_low: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> (pwm_out == '0));

endmodule

// File: tb/tb_dual_pwm_dac.sv
`timescale 1ns/1ps
module tb_dual_pwm_dac;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       shutdown = 1'b0;
    logic       pulse_mode = 1'b1;
    logic [1:0] raise_in = '0;
    logic [1:0] lower_in = '0;
    logic [1:0] pwm_out;

    int checks = 0;
    int errors = 0;
    int model [2];
    bit done = 0;

    always #2.5 clk = ~clk;

    dual_pwm_dac #(
        .CODE_W(6), .TICK_DIV(4), .DEB_SAMPLES(16), .N_CH(2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .shutdown(shutdown), .pulse_mode(pulse_mode),
        .raise_in(raise_in), .lower_in(lower_in), .pwm_out(pwm_out)
    );

    function automatic int sat_step(int lvl, bit up, bit dn);
        if (up && !dn && lvl < 63) return lvl + 1;
        if (dn && !up && lvl > 0) return lvl - 1;
        return lvl;
    endfunction

    task automatic check(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic duty(int ch, output int d);
        repeat (140) @(negedge clk);
        d = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            d += int'(pwm_out[ch]);
        end
    endtask

    task automatic pulse(int ch, bit up, bit dn);
        @(negedge clk);
        raise_in[ch] = up;
        lower_in[ch] = dn;
        repeat (2) @(negedge clk);
        raise_in[ch] = 1'b0;
        lower_in[ch] = 1'b0;
        repeat (3) @(negedge clk);
        model[ch] = sat_step(model[ch], up, dn);
    endtask

    task automatic check_both(string req);
        int d;
        for (int c = 0; c < 2; c++) begin
            duty(c, d);
            check(req, d, model[c]);
        end
    endtask

    task automatic runs_ok(int ch, int a, int b, output int bad);
        bit prev;
        int run;
        int seen;
        bad = -1;
        prev = pwm_out[ch];
        while (!(prev && !pwm_out[ch])) begin
            prev = pwm_out[ch];
            @(negedge clk);
        end
        run = 0;
        seen = 0;
        while (seen < 4) begin
            @(negedge clk);
            if (pwm_out[ch]) run++;
            else if (run > 0) begin
                if (run != a && run != b) bad = run;
                run = 0;
                seen++;
            end
        end
    endtask

    initial begin
        int d;
        int bad;
        void'($urandom(32'd4242));
        model[0] = 32;
        model[1] = 32;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        check_both("R1 reset midscale");

        pulse(0, 1, 0);
        check_both("R3 pulse raise ch0 / R10");
        pulse(1, 0, 1);
        pulse(1, 0, 1);
        check_both("R3 pulse lower ch1 / R10");

        for (int i = 0; i < 48; i++) begin
            int ch;
            int op;
            ch = int'($urandom_range(0, 1));
            op = int'($urandom_range(0, 2));
            pulse(ch, op == 0, op == 1);
            if (i % 8 == 7) check_both("R2 random duty");
        end

        pulse(0, 1, 1);
        check_both("R9 simultaneous raise and lower");

        for (int i = 0; i < 70; i++) pulse(0, 1, 0);
        duty(0, d);
        check("R6 level 63 duty", d, 63);
        pulse(0, 1, 0);
        duty(0, d);
        check("R5 saturate at 63", d, 63);

        for (int i = 0; i < 70; i++) pulse(1, 0, 1);
        duty(1, d);
        check("R6 level 0 duty", d, 0);
        pulse(1, 0, 1);
        duty(1, d);
        check("R5 saturate at 0", d, 0);

        for (int i = 0; i < 30; i++) pulse(1, 1, 0);
        duty(1, d);
        check("R2 level 30 after rise from 0", d, model[1]);
        repeat (37) @(negedge clk);
        fork
            pulse(1, 1, 0);
            runs_ok(1, 30, 31, bad);
        join
        check("R8 no runt pulse", bad, -1);

        pulse_mode = 1'b0;
        repeat (10) @(negedge clk);
        raise_in[1] = 1'b1;
        repeat (20) @(negedge clk);
        raise_in[1] = 1'b0;
        check_both("R4 short glitch ignored");
        raise_in[1] = 1'b1;
        repeat (150) @(negedge clk);
        raise_in[1] = 1'b0;
        repeat (150) @(negedge clk);
        model[1] = sat_step(model[1], 1, 0);
        check_both("R4 debounced press one step");
        lower_in[0] = 1'b1;
        repeat (150) @(negedge clk);
        lower_in[0] = 1'b0;
        repeat (150) @(negedge clk);
        model[0] = sat_step(model[0], 0, 1);
        check_both("R4 debounced lower press");

        @(negedge clk);
        shutdown = 1'b1;
        repeat (3) @(negedge clk);
        d = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            d += int'(pwm_out[0]) + int'(pwm_out[1]);
        end
        check("R7 outputs low in shutdown", d, 0);
        shutdown = 1'b0;
        model[0] = 32;
        model[1] = 32;
        check_both("R7 midscale after shutdown");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule